// File: doc/BRIEF.md
# Segmentable Tapped Shift Register

A 64-stage static shift register with one serial data input, one mode control and four tap ports placed at stages 16, 32, 48 and 64. With the mode control low the stages form a single 64-deep chain, and the four taps drive out the contents of their stages. With the mode control high the tap drivers are switched off and the chain breaks into four 16-stage segments. The ports at stages 16, 32 and 48 then act as serial inputs that feed stages 17, 33 and 49.

Each bidirectional tap is modelled as separate signals so that the block stays synthesizable. `tap_out` carries the stage value. `tap_oe` enables the external driver. `tap_in` carries the level that is present on the pad. The stage-64 tap is never an input, so it has no `tap_in` bit. The surrounding pad logic builds the tristate from `tap_out` and `tap_oe`. The block has no reset. A synchronous clear input brings the stages to a known state. Segment length and segment count are parameters, and the defaults give 4 × 16.

Top module: `seg_tap_shreg`

## Requirements
- R1: When `clr` is high at a rising edge, all stages become 0, and this takes priority over every shift and load. After that edge, all `tap_out` bits read 0.
- R2: On every rising edge with `clr` low, stage 1 loads `din`, in either mode.
- R3: With `split` low, each rising edge moves every stage k to stage k+1 for k from 1 to 63. A bit entered at `din` appears on `tap_out[0]` after 16 edges and on `tap_out[3]` after 64 edges.
- R4: `tap_oe` is all ones while `split` is low and all zeros while `split` is high. Bit j belongs to the tap at stage 16·(j+1).
- R5: With `split` high, each rising edge loads stage 17 from `tap_in[0]`, stage 33 from `tap_in[1]` and stage 49 from `tap_in[2]`. Inside each segment, the stages shift by one.
- R6: With `split` high, no data crosses a segment boundary. Stage 17 never takes stage 16, stage 33 never takes stage 32, and stage 49 never takes stage 48.
- R7: `tap_out[j]` always shows stage 16·(j+1), in both modes. With `split` high, the value is only withheld from the pad, through `tap_oe`.
- R8: A falling clock edge never changes any stage or `tap_out` bit.
- R9: Changing `split` between edges keeps all stage contents. The next edge shifts according to the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; stages update on the rising edge |
| clr | input | 1 | Synchronous clear of all stages |
| din | input | 1 | Serial data into stage 1 |
| split | input | 1 | 0: one 64-stage chain, taps driven; 1: four segments, taps released |
| tap_in | input | NUM_SEG-1 | Pad levels of the taps at stages 16, 32, 48 (bit 0 = stage 16) |
| tap_out | output | NUM_SEG | Contents of stages 16, 32, 48, 64 (bit 0 = stage 16) |
| tap_oe | output | NUM_SEG | Tap driver enables, one per tap |

## Verification
The bench targets the three segment joins in split mode. A design that still chains across a boundary would leak `din` data into stages 17 and beyond instead of taking `tap_in`. A design that swaps the `tap_in` bits would fill the wrong segment. Mode switches every few edges during a stream catch designs that flush or corrupt contents on a mode change, and designs that apply the old mode for one edge. A clear asserted together with `din` high catches a clear with the wrong priority. Samples taken after each falling edge catch registers that move on both edges.

// File: rtl/seg_tap_shreg.sv
module seg_tap_shreg #(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               din,
  input  logic               split,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);
  localparam int DEPTH = SEG_LEN * NUM_SEG;

  logic [DEPTH-1:0] st;
  logic [DEPTH-1:0] nxt;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam int HEAD = g * SEG_LEN;
    localparam int TAIL = HEAD + SEG_LEN - 1;

    if (g == 0) begin : g_first
      assign nxt[HEAD] = din;
    end else begin : g_join
      assign nxt[HEAD] = split ? tap_in[g-1] : st[HEAD-1];

      p_join_r5: assert property (@(posedge clk) disable iff (clr)
        (!$past(clr) && $past(split)) |-> (st[HEAD] == $past(tap_in[g-1])))
        else $error("segment head did not load its tap input");
    end

    if (SEG_LEN > 1) begin : g_body
      assign nxt[TAIL:HEAD+1] = st[TAIL-1:HEAD];

      p_tap_shift_r3: assert property (@(posedge clk) disable iff (clr)
        !$past(clr) |-> (tap_out[g] == $past(st[TAIL-1])))
        else $error("tap did not advance by one stage");
    end

    assign tap_out[g] = st[TAIL];
  end

  always_ff @(posedge clk) begin
    if (clr) st <= '0;
    else     st <= nxt;
  end

  assign tap_oe = {NUM_SEG{~split}};

  p_clear_r1: assert property (@(posedge clk) disable iff (clr)
    $past(clr) |-> (tap_out == '0))
    else $error("taps not zero after clear");

  p_oe_r4: assert property (@(posedge clk) disable iff (clr)
    split |-> (tap_oe == '0))
    else $error("tap drivers active in split mode");

endmodule

// File: tb/seg_tap_shreg_test.sv
module seg_tap_shreg_test;
  localparam int SEG = 16;
  localparam int NS = 4;
  localparam int D = SEG * NS;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic din = 1'b0;
  logic split = 1'b0;
  logic [NS-2:0] tap_in = '0;
  logic [NS-1:0] tap_out;
  logic [NS-1:0] tap_oe;

  int errors = 0;
  int checks = 0;
  logic mdl [1:D];
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  seg_tap_shreg #(.SEG_LEN(SEG), .NUM_SEG(NS)) uut (
    .clk(clk), .clr(clr), .din(din), .split(split),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
  );

  function automatic logic [NS-1:0] exp_taps();
    logic [NS-1:0] v;
    for (int j = 0; j < NS; j++) v[j] = mdl[SEG*(j+1)];
    return v;
  endfunction

  task automatic check(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge(input logic c, input logic d, input logic sp, input logic [NS-2:0] ti);
    logic nx [1:D];
    for (int k = 1; k <= D; k++) begin
      if (c) nx[k] = 1'b0;
      else if (k == 1) nx[k] = d;
      else if (sp && ((k - 1) % SEG == 0)) nx[k] = ti[(k-1)/SEG - 1];
      else nx[k] = mdl[k-1];
    end
    for (int k = 1; k <= D; k++) mdl[k] = nx[k];
  endtask

  task automatic step(input string req, input logic c, input logic d, input logic sp, input logic [NS-2:0] ti);
    logic [NS-1:0] after_rise;
    clr = c; din = d; split = sp; tap_in = ti;
    @(posedge clk);
    model_edge(c, d, sp, ti);
    #2;
    check(req, tap_out, exp_taps());
    check("R4", tap_oe, sp ? '0 : '1);
    after_rise = tap_out;
    @(negedge clk);
    #1;
    check("R8", tap_out, after_rise);
  endtask

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic t_clear();
    step("R1", 1'b1, 1'b1, 1'b0, '1);
    step("R1", 1'b1, 1'b1, 1'b0, '1);
    check("R1", tap_out, 4'b0000);
  endtask

  task automatic t_serial();
    step("R2", 1'b0, 1'b1, 1'b0, '0);
    for (int i = 0; i < 15; i++) step("R3", 1'b0, 1'b0, 1'b0, '1);
    check("R3", tap_out, 4'b0001);
    for (int i = 0; i < 48; i++) step("R3", 1'b0, 1'b0, 1'b0, '1);
    check("R3", tap_out, 4'b1000);
    for (int i = 0; i < 70; i++) step("R3", 1'b0, rnd(), 1'b0, '0);
  endtask

  task automatic t_split();
    for (int i = 0; i < D; i++) step("R3", 1'b0, 1'b1, 1'b0, '0);
    check("R3", tap_out, 4'b1111);
    for (int i = 0; i < SEG; i++) step("R6", 1'b0, 1'b1, 1'b1, 3'b000);
    check("R6", tap_out, 4'b0001);
    for (int i = 0; i < SEG; i++) step("R5", 1'b0, 1'b0, 1'b1, 3'b101);
    check("R5", tap_out, 4'b1010);
    for (int i = 0; i < 40; i++)
      step("R7", 1'b0, rnd(), 1'b1, {rnd(), rnd(), rnd()});
  endtask

  task automatic t_switch();
    for (int i = 0; i < 90; i++)
      step("R9", 1'b0, rnd(), ((i / 5) % 2) == 1, {rnd(), rnd(), rnd()});
    for (int i = 0; i < 30; i++)
      step("R9", 1'b0, rnd(), rnd(), {rnd(), rnd(), rnd()});
  endtask

  initial begin
    for (int k = 1; k <= D; k++) mdl[k] = 1'b0;
    @(negedge clk);
    #1;
    t_clear();
    t_serial();
    t_split();
    t_switch();
    t_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule